// File: doc/BRIEF.md
# Ethernet MAC Interrupt Aggregator

This block gathers the condition pulses raised by one or more Ethernet MAC channels and their DMA engines and turns them into three interrupt requests per channel: an error/diagnostic summary, a receive-complete request and a transmit-complete request. Each channel keeps a bank of sticky condition flags and an enable word. The error request is the registered OR of every flag whose enable is set. The enable word also holds two group enables: one covers the abnormal conditions and one covers the normal receive/transmit conditions.

Receive-complete and transmit-complete are sticky request bits. The receive request honours a pass-bad-frame mode bit. The transmit request fires either on written-back frame status or on a stop descriptor. A simple register port reads all state, writes the enable word and clears sticky bits by writing 1. Address bits [1:0] select the register and the bits above them select the channel. The default build holds two channels.

Condition flag index (used in the flag and enable registers): 0 error summary, 1 transmit underflow, 2 transmit overflow, 3 receive overrun, 4 transmit jabber, 5 receive watchdog, 6 receive interrupt, 7 transmit interrupt, 8 auxiliary "AU" flag, 9 transmit buffer unavailable, 10 excessive deferral, 11 deferred, 12 receive list done, 13 transmit failure, 14 no carrier, 15 lost carrier, 16 sixteen collisions, 17 late collision.

Top module: `maci_aggregator`

## Requirements
- R1: Channels are independent: pulses, writes and clears aimed at one channel never change another channel's flags, enables, requests or outputs.
- R2: A 1 on bit k of a channel's flag pulse input sets flag k on the next clock edge. The flag stays set and reads back at register select 0, bits [17:0].
- R3: Writing register select 0 clears each flag whose write-data bit is 1 and leaves the others unchanged. A pulse and a clear on the same flag in the same cycle leave it set.
- R4: Register select 1 holds the enable word in bits [17:0] and the pass-bad-frame bit in bit 18. It is read/write. Select 3 reads zero.
- R5: For every flag k other than 0 and 3, enable bit k alone makes irq_err high one clock after flag k and enable k are both set.
- R6: Enable bit 0 is the abnormal group enable. It raises irq_err when any of flags 0 to 5 is set.
- R7: Enable bit 3 is the normal group enable. It raises irq_err when flag 6 or flag 7 is set.
- R8: irq_err is low one clock after no set flag is covered by its own enable or by a group enable. Flags 0 and 3 have no own enable.
- R9: With pass-bad-frame at 0, a receive-done pulse sets the receive request only if the good-frame input is 1.
- R10: With pass-bad-frame at 1, a receive-done pulse sets the receive request whatever the good-frame input is.
- R11: A transmit-status-done pulse or a stop-descriptor pulse sets the transmit request.
- R12: Register select 2 shows the receive request in bit 0 and the transmit request in bit 1. Writing 1 clears a request. A set and a clear in the same cycle leave it set.
- R13: After reset, all flags, enables, pass-bad-frame, requests and the three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_evt_i | input | NUM_MACS*18 | Condition pulses, 18 per channel, channel 0 in the low bits |
| rx_done_i | input | NUM_MACS | Receive status written back, one per channel |
| rx_good_i | input | NUM_MACS | Frame written back was good |
| tx_done_i | input | NUM_MACS | Transmit status written back |
| tx_stop_i | input | NUM_MACS | Descriptor fetched with ready bit clear |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | MAC_IDX_W+2 | {channel, select} |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| irq_err_o | output | NUM_MACS | Registered error/diagnostic request |
| irq_rx_o | output | NUM_MACS | Sticky receive-complete request |
| irq_tx_o | output | NUM_MACS | Sticky transmit-complete request |

## Verification
The bench builds the block with NUM_MACS = 2 and DATA_W = 32. Two channels bring address decoding of the channel field into reach. They also let a clear or a pulse on one channel be watched for leaks into the other. The 32-bit data word reaches the pass-bad-frame bit at position 18 and the zero upper bits, so enable-word readback covers the whole layout. A long pseudo-random phase mixes pulses, enable writes and clears on both channels against the cycle model.

// File: rtl/maci_pkg.sv
package maci_pkg;

    localparam int N_STAT     = 18;
    localparam int PBF_BIT    = 18;
    localparam int ABN_EN_BIT = 0;
    localparam int NRM_EN_BIT = 3;
    localparam int WORD_W     = PBF_BIT + 1;

    typedef logic [N_STAT-1:0] stat_t;

    // flags covered by the abnormal group enable
    localparam stat_t ABN_SET    = 18'h0003F;
    // flags covered by the normal group enable
    localparam stat_t NRM_SET    = 18'h000C0;
    // flags that pair with an enable bit of the same index
    localparam stat_t OWN_EN_SET = 18'h3FFF6;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_EN   = 2'd1,
        SEL_REQ  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef struct packed {
        stat_t st;
        stat_t en;
        logic  pbf;
    } bank_s;

    typedef struct packed {
        logic err;
    } err_s;

    typedef struct packed {
        logic rx;
        logic tx;
    } req_s;

endpackage

// File: rtl/maci_status_bank.sv
module maci_status_bank
    import maci_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  stat_t             evt_i,
    input  logic              clr_we_i,
    input  logic              en_we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output stat_t             st_o,
    output stat_t             en_o,
    output logic              pbf_o
);

    bank_s bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (en_we_i) begin
            bank_d.en  = wdata_i[N_STAT-1:0];
            bank_d.pbf = wdata_i[PBF_BIT];
        end
        if (clr_we_i) begin
            bank_d.st = bank_q.st & ~wdata_i[N_STAT-1:0];
        end
        bank_d.st = bank_d.st | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign st_o  = bank_q.st;
    assign en_o  = bank_q.en;
    assign pbf_o = bank_q.pbf;

    // a pulse always lands in the flag, even against a clear
    assert_evt_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((st_o & $past(evt_i)) == $past(evt_i)));

    // without pulse or clear the flags keep their value
    assert_flags_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(|evt_i) && !clr_we_i) |=> $stable(st_o));

    // enable word changes only through a write
    assert_en_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_we_i) |=> ($stable(en_o) && $stable(pbf_o)));

endmodule

// File: rtl/maci_err_merge.sv
module maci_err_merge
    import maci_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  stat_t st_i,
    input  stat_t en_i,
    output logic  err_o
);

    err_s err_d, err_q;
    logic own_hit;
    logic abn_hit;
    logic nrm_hit;

    always_comb begin
        own_hit   = |(st_i & en_i & OWN_EN_SET);
        abn_hit   = en_i[ABN_EN_BIT] && (|(st_i & ABN_SET));
        nrm_hit   = en_i[NRM_EN_BIT] && (|(st_i & NRM_SET));
        err_d.err = own_hit || abn_hit || nrm_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_o = err_q.err;

    // nothing enabled: no error request
    assert_quiet_when_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i == '0) |=> !err_o);

    // no flag set: no error request
    assert_quiet_when_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == '0) |=> !err_o);

    // a flag with its own enable raises the request
    assert_own_enable_fires_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(st_i & en_i & OWN_EN_SET)) |=> err_o);

    // abnormal group enable covers the first six flags
    assert_abn_group_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i[ABN_EN_BIT] && (|st_i[5:0])) |=> err_o);

endmodule

// File: rtl/maci_req_latch.sv
module maci_req_latch
    import maci_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rx_done_i,
    input  logic       rx_good_i,
    input  logic       pbf_i,
    input  logic       tx_done_i,
    input  logic       tx_stop_i,
    input  logic       clr_we_i,
    input  logic [1:0] wdata_i,
    output logic       rx_o,
    output logic       tx_o
);

    req_s req_d, req_q;
    logic rx_set;
    logic tx_set;

    always_comb begin
        rx_set = rx_done_i && (rx_good_i || pbf_i);
        tx_set = tx_done_i || tx_stop_i;
        req_d  = req_q;
        if (clr_we_i) begin
            req_d.rx = req_q.rx && !wdata_i[0];
            req_d.tx = req_q.tx && !wdata_i[1];
        end
        req_d.rx = req_d.rx || rx_set;
        req_d.tx = req_d.tx || tx_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign rx_o = req_q.rx;
    assign tx_o = req_q.tx;

    // bad frame dropped when pass-bad-frame is off
    assert_bad_frame_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_done_i && !rx_good_i && !pbf_i && !rx_o) |=> !rx_o);

    // accepted frame sets the receive request, even against a clear
    assert_rx_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_done_i && (rx_good_i || pbf_i)) |=> rx_o);

    // stop descriptor or status write-back sets the transmit request
    assert_tx_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_stop_i || tx_done_i) |=> tx_o);

    // requests fall only through a clear write
    assert_req_falls_by_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_we_i) |=> !$fell(rx_o) && !$fell(tx_o));

endmodule

// File: rtl/maci_aggregator.sv
module maci_aggregator
    import maci_pkg::*;
#(
    parameter int NUM_MACS  = 2,
    parameter int DATA_W    = 32,
    parameter int MAC_IDX_W = (NUM_MACS > 1) ? $clog2(NUM_MACS) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_MACS*N_STAT-1:0] stat_evt_i,
    input  logic [NUM_MACS-1:0]        rx_done_i,
    input  logic [NUM_MACS-1:0]        rx_good_i,
    input  logic [NUM_MACS-1:0]        tx_done_i,
    input  logic [NUM_MACS-1:0]        tx_stop_i,
    input  logic                       reg_wr_i,
    input  logic [MAC_IDX_W+1:0]       reg_addr_i,
    input  logic [DATA_W-1:0]          reg_wdata_i,
    output logic [DATA_W-1:0]          reg_rdata_o,
    output logic [NUM_MACS-1:0]        irq_err_o,
    output logic [NUM_MACS-1:0]        irq_rx_o,
    output logic [NUM_MACS-1:0]        irq_tx_o
);

    localparam int ADDR_W = MAC_IDX_W + 2;

    logic [MAC_IDX_W-1:0] mac_sel;
    sel_e                 reg_sel;
    logic [WORD_W-1:0]    wword;
    logic                 unused_wdata_bits;

    stat_t st_w  [NUM_MACS];
    stat_t en_w  [NUM_MACS];
    logic  pbf_w [NUM_MACS];

    assign mac_sel           = reg_addr_i[ADDR_W-1:2];
    assign reg_sel           = sel_e'(reg_addr_i[1:0]);
    assign wword             = reg_wdata_i[WORD_W-1:0];
    assign unused_wdata_bits = ^reg_wdata_i[DATA_W-1:WORD_W];

    for (genvar m = 0; m < NUM_MACS; m++) begin : g_mac
        logic hit;
        logic clr_stat_we;
        logic en_we;
        logic clr_req_we;

        assign hit         = reg_wr_i && (mac_sel == MAC_IDX_W'(m));
        assign clr_stat_we = hit && (reg_sel == SEL_STAT);
        assign en_we       = hit && (reg_sel == SEL_EN);
        assign clr_req_we  = hit && (reg_sel == SEL_REQ);

        maci_status_bank u_bank (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .evt_i    (stat_evt_i[m*N_STAT +: N_STAT]),
            .clr_we_i (clr_stat_we),
            .en_we_i  (en_we),
            .wdata_i  (wword),
            .st_o     (st_w[m]),
            .en_o     (en_w[m]),
            .pbf_o    (pbf_w[m])
        );

        maci_err_merge u_err (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .st_i   (st_w[m]),
            .en_i   (en_w[m]),
            .err_o  (irq_err_o[m])
        );

        maci_req_latch u_req (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .rx_done_i (rx_done_i[m]),
            .rx_good_i (rx_good_i[m]),
            .pbf_i     (pbf_w[m]),
            .tx_done_i (tx_done_i[m]),
            .tx_stop_i (tx_stop_i[m]),
            .clr_we_i  (clr_req_we),
            .wdata_i   (wword[1:0]),
            .rx_o      (irq_rx_o[m]),
            .tx_o      (irq_tx_o[m])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int m = 0; m < NUM_MACS; m++) begin
            if (mac_sel == MAC_IDX_W'(m)) begin
                case (reg_sel)
                    SEL_STAT: reg_rdata_o[N_STAT-1:0] = st_w[m];
                    SEL_EN: begin
                        reg_rdata_o[N_STAT-1:0] = en_w[m];
                        reg_rdata_o[PBF_BIT]    = pbf_w[m];
                    end
                    SEL_REQ: begin
                        reg_rdata_o[0] = irq_rx_o[m];
                        reg_rdata_o[1] = irq_tx_o[m];
                    end
                    default: reg_rdata_o = '0;
                endcase
            end
        end
    end

    // all outputs low right after reset
    assert_reset_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (irq_err_o == '0 && irq_rx_o == '0 && irq_tx_o == '0));

endmodule

// File: tb/maci_aggregator_bench.sv
module maci_aggregator_bench;

    localparam int NM = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [35:0]   evt = '0;
    logic [1:0]    rxd = '0, rxg = '0, txd = '0, txs = '0;
    logic          wr = 1'b0;
    logic [2:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [1:0]    ierr, irx, itx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    maci_aggregator #(.NUM_MACS(NM), .DATA_W(32)) u_maci_aggregator (
        .clk_i(clk), .rst_ni(rst_n), .stat_evt_i(evt),
        .rx_done_i(rxd), .rx_good_i(rxg), .tx_done_i(txd), .tx_stop_i(txs),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_err_o(ierr), .irq_rx_o(irx), .irq_tx_o(itx)
    );

    // reference model
    bit [17:0] mst [NM];
    bit [17:0] men [NM];
    bit        mpbf[NM], mrx[NM], mtx[NM], merr[NM];

    function automatic bit err_of(bit [17:0] s, bit [17:0] e);
        bit r = 0;
        for (int k = 0; k < 18; k++)
            if (k != 0 && k != 3 && s[k] && e[k]) r = 1;
        if (e[0] && (s[0] || s[1] || s[2] || s[3] || s[4] || s[5])) r = 1;
        if (e[3] && (s[6] || s[7])) r = 1;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < NM; m++) begin
                mst[m] = 0; men[m] = 0; mpbf[m] = 0;
                mrx[m] = 0; mtx[m] = 0; merr[m] = 0;
            end
        end else begin
            for (int m = 0; m < NM; m++) begin
                bit me;
                me = wr && (addr[2] == m[0]);
                merr[m] = err_of(mst[m], men[m]);
                if (me && addr[1:0] == 2'd0) mst[m] = mst[m] & ~wdata[17:0];
                mst[m] = mst[m] | evt[m*18 +: 18];
                if (me && addr[1:0] == 2'd2) begin
                    if (wdata[0]) mrx[m] = 0;
                    if (wdata[1]) mtx[m] = 0;
                end
                if (rxd[m] && (rxg[m] || mpbf[m])) mrx[m] = 1;
                if (txd[m] || txs[m]) mtx[m] = 1;
                if (me && addr[1:0] == 2'd1) begin
                    men[m]  = wdata[17:0];
                    mpbf[m] = wdata[18];
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [2:0] a);
        int m = a[2];
        logic [31:0] r = '0;
        case (a[1:0])
            2'd0: r[17:0] = mst[m];
            2'd1: begin r[17:0] = men[m]; r[18] = mpbf[m]; end
            2'd2: begin r[0] = mrx[m]; r[1] = mtx[m]; end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        for (int m = 0; m < NM; m++) begin
            check(ierr[m] === merr[m], tag, $sformatf("irq_err[%0d]", m), 32'(ierr[m]), 32'(merr[m]));
            check(irx[m] === mrx[m], tag, $sformatf("irq_rx[%0d]", m), 32'(irx[m]), 32'(mrx[m]));
            check(itx[m] === mtx[m], tag, $sformatf("irq_tx[%0d]", m), 32'(itx[m]), 32'(mtx[m]));
        end
        check(rdata === exp_rd(addr), tag, $sformatf("rdata@%0d", addr), rdata, exp_rd(addr));
    endtask

    // one clock: inputs already set, sample at the falling edge, then idle
    task automatic tick(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
        evt = '0; rxd = '0; rxg = '0; txd = '0; txs = '0; wr = 1'b0; wdata = '0;
    endtask

    task automatic wr_reg(input int m, input int sel, input logic [31:0] d, input string tag);
        wr = 1'b1; addr = {m[0], sel[1:0]}; wdata = d;
        tick(tag);
    endtask

    task automatic look(input int m, input int sel, input string tag);
        addr = {m[0], sel[1:0]};
        tick(tag);
    endtask

    bit [31:0] lf = 32'h1ace_b00c;
    function automatic bit [31:0] nxt();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        return lf;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state
        look(0, 1, "R13");
        look(1, 0, "R13");
        look(0, 2, "R13");
        // R4: enable word readback, select 3 reads zero
        wr_reg(0, 1, 32'h0007_FFFF, "R4");
        look(0, 1, "R4");
        look(0, 3, "R4");
        wr_reg(0, 1, 32'h0, "R4");
        // R2/R8: flag without enable, no error
        evt[10] = 1'b1; look(0, 0, "R2");
        look(0, 0, "R8");
        // R5: own enable raises error
        wr_reg(0, 1, 32'h0000_0400, "R5");
        look(0, 0, "R5");
        // R3: set wins against clear, then clear alone
        evt[10] = 1'b1; wr_reg(0, 0, 32'h0000_0400, "R3");
        look(0, 0, "R3");
        wr_reg(0, 0, 32'h0000_0400, "R3");
        look(0, 0, "R3");
        look(0, 0, "R8");
        // R6: abnormal group covers receive overrun
        wr_reg(0, 1, 32'h0000_0001, "R6");
        evt[3] = 1'b1; look(0, 0, "R6");
        look(0, 0, "R6");
        wr_reg(0, 0, 32'h0000_0008, "R6");
        // R7/R8: normal group ignores overrun, covers receive interrupt
        wr_reg(0, 1, 32'h0000_0008, "R7");
        evt[3] = 1'b1; look(0, 0, "R8");
        look(0, 0, "R8");
        evt[6] = 1'b1; look(0, 0, "R7");
        look(0, 0, "R7");
        wr_reg(0, 0, 32'h0003_FFFF, "R7");
        look(0, 0, "R7");
        // R5: auxiliary flag with own enable
        wr_reg(0, 1, 32'h0000_0100, "R5");
        evt[8] = 1'b1; look(0, 0, "R5");
        look(0, 0, "R5");
        wr_reg(0, 0, 32'h0000_0100, "R5");
        // R1: channel 1 activity leaves channel 0 alone
        evt[18 + 9] = 1'b1; rxd[1] = 1'b1; rxg[1] = 1'b1; txs[1] = 1'b1; look(0, 0, "R1");
        wr_reg(1, 1, 32'h0000_0200, "R1");
        look(0, 1, "R1");
        look(1, 0, "R1");
        wr_reg(0, 2, 32'h3, "R1");
        look(1, 2, "R1");
        // R9: pass-bad-frame off
        rxd[0] = 1'b1; rxg[0] = 1'b0; look(0, 2, "R9");
        rxd[0] = 1'b1; rxg[0] = 1'b1; look(0, 2, "R9");
        // R12: clear, set-wins
        wr_reg(0, 2, 32'h1, "R12");
        rxd[0] = 1'b1; rxg[0] = 1'b1; wr_reg(0, 2, 32'h1, "R12");
        wr_reg(0, 2, 32'h1, "R12");
        look(0, 2, "R12");
        // R10: pass-bad-frame on
        wr_reg(0, 1, 32'h0004_0000, "R10");
        rxd[0] = 1'b1; rxg[0] = 1'b0; look(0, 2, "R10");
        wr_reg(0, 2, 32'h1, "R10");
        // R11: stop descriptor and status write-back
        txs[0] = 1'b1; look(0, 2, "R11");
        wr_reg(0, 2, 32'h2, "R11");
        txd[0] = 1'b1; look(0, 2, "R11");
        txd[0] = 1'b1; wr_reg(0, 2, 32'h2, "R12");
        // mixed traffic on both channels
        for (int i = 0; i < 600; i++) begin
            bit [31:0] a, b, c;
            a = nxt(); b = nxt(); c = nxt();
            evt   = {a[17:0] & b[17:0] & c[17:0], b[17:0] & c[17:0] & a[31:14]};
            rxd   = a[21:20] & b[21:20];
            rxg   = c[3:2];
            txd   = a[25:24] & c[25:24];
            txs   = b[27:26] & c[27:26];
            addr  = c[10:8];
            wr    = (a[5:3] == 3'b101);
            wdata = {13'h0, b[18:0] & (c[12] ? a[18:0] : 19'h7FFFF)};
            tick(i % 2 == 0 ? "R5" : "R12");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R13 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule